// File: doc/BRIEF.md
# Ultra DMA Write-Path Flow Controller

This block sits between a host-facing Ultra DMA port and a drive-facing Ultra DMA port during a write-direction DMA command. Host data lands in an input FIFO, an external datapath transforms it, and the result leaves through an output FIFO toward the drive. The controller does not move data. It decides when each of the two bursts is opened, paused and closed, and it checks each burst's CRC when the burst ends.

Each side has a request/acknowledge pair. The controller holds a request high while it wants that channel up, and the peer raises its acknowledge once the channel is established. Dropping a request asks that peer to stop, and the channel counts as closed once the acknowledge falls. The two bursts are coupled. If the drive ends its burst, both channels collapse. If the host ends its burst, the drive side keeps draining the output FIFO. When the drive asks again and the host has nothing left to send, only the drive side is reopened.

Top module: `udma_flow_ctrl`

## Requirements
- R1: During and right after reset, every output is low and the controller is idle. In the idle state it reacts only to `cmd_start`, which arms it to wait for the drive.
- R2: While armed, `drv_dmarq` with `host_has_data` high raises `host_req` on the next cycle. `drv_req` rises only in the cycle after `host_ack` is seen high, and the controller enters transfer once `drv_ack` is seen.
- R3: `drv_go` is high only when `drv_req` and `drv_ack` are both high, `drv_pause` is low and `out_empty` is low. It is never high while the drive channel is still opening.
- R4: `host_pause` is high exactly when `host_req`, `host_ack` and `in_full` are all high.
- R5: `drv_stop` during transfer drops `drv_req` on the next cycle while `host_req` stays high. `host_req` drops only in the cycle after `drv_ack` is seen low. Once `host_ack` is low the controller returns to waiting.
- R6: `host_stop` during transfer drops `host_req` on the next cycle and keeps `drv_req` high. After `host_ack` falls, draining continues until `out_empty` (or `drv_stop`) is seen. `drv_req` then drops, and the controller waits once `drv_ack` is low.
- R7: While waiting, `drv_dmarq` with `host_has_data` low raises only `drv_req`. `host_req` stays low through that whole drain burst.
- R8: While waiting, `drv_intrq` produces one-cycle pulses on `result_copy` and `host_irq` on the next cycle and returns the controller to idle. It takes priority over a `drv_dmarq` that arrives in the same cycle.
- R9: Each channel's CRC is seeded with 0x4ABA when that channel's request rises. It is updated for every accepted 16-bit word with polynomial 0x1021, taking word bits 15 down to 0, and each bit is handled as fb = crc[15]^d, crc = {crc[14:0],0} ^ (fb ? 0x1021 : 0). Host words count when `h_word_vld`, `host_req` and `host_ack` are all high. Drive words count when `d_word_vld` and `drv_go` are both high. When a channel closes, `crc_chk` pulses for one cycle and the running value is compared with `host_crc_in` or `drv_crc_in`. A mismatch sets `crc_err`, which stays set until the next `cmd_start`.
- R10: If `drv_stop` and `host_stop` arrive in the same transfer cycle, the drive-initiated collapse of R5 is taken.
- R11: `drv_dmarq`, `drv_stop`, `host_stop` and `drv_intrq` have no effect while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | A write DMA command has been issued |
| drv_dmarq | input | 1 | Drive requests a DMA burst |
| drv_pause | input | 1 | Drive asks for a pause in data flow |
| drv_stop | input | 1 | Drive ends its burst |
| drv_intrq | input | 1 | Drive signals that the command is complete |
| host_stop | input | 1 | Host ends its burst |
| host_has_data | input | 1 | Host still holds data for this command |
| in_full | input | 1 | Input FIFO is full |
| out_empty | input | 1 | Output FIFO is empty |
| host_ack | input | 1 | Host channel is established |
| drv_ack | input | 1 | Drive channel is established |
| h_word_vld | input | 1 | A host word is strobed in |
| h_word | input | W | Host word |
| d_word_vld | input | 1 | A word is strobed to the drive |
| d_word | input | W | Drive word |
| host_crc_in | input | W | CRC sent by the host at burst end |
| drv_crc_in | input | W | CRC computed by the drive at burst end |
| host_req | output | 1 | Open or hold the host channel |
| drv_req | output | 1 | Open or hold the drive channel |
| host_pause | output | 1 | Ask the host to pause |
| drv_go | output | 1 | Words may flow to the drive |
| crc_chk | output | 1 | A CRC comparison happens this cycle |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| result_copy | output | 1 | Copy the drive's result registers |
| host_irq | output | 1 | Interrupt pulse to the host |

## Verification
The first command runs one coupled burst with host and drive words on every cycle. During it, full, empty and pause are toggled out of phase, so each gating term of `drv_go` and `host_pause` is separated from the others. Later bursts contrast the two stop origins. A drive stop must collapse both channels. A host stop must keep the drive draining, which is shown by holding `out_empty` low for several cycles after the host channel has closed. A reopen without host data shows that the host side stays shut. Matching CRCs in the first burst and a corrupted drive CRC later show both that the check fires and that the error flag stays set. Simultaneous stops and a simultaneous interrupt plus request pin down both priority rules.

// File: rtl/udma_flow_ctrl.sv
module udma_flow_ctrl #(
  parameter int W = 16,
  parameter logic [W-1:0] CRC_POLY = 16'h1021,
  parameter logic [W-1:0] CRC_SEED = 16'h4ABA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_start,
  input  logic         drv_dmarq,
  input  logic         drv_pause,
  input  logic         drv_stop,
  input  logic         drv_intrq,
  input  logic         host_stop,
  input  logic         host_has_data,
  input  logic         in_full,
  input  logic         out_empty,
  input  logic         host_ack,
  input  logic         drv_ack,
  input  logic         h_word_vld,
  input  logic [W-1:0] h_word,
  input  logic         d_word_vld,
  input  logic [W-1:0] d_word,
  input  logic [W-1:0] host_crc_in,
  input  logic [W-1:0] drv_crc_in,
  output logic         host_req,
  output logic         drv_req,
  output logic         host_pause,
  output logic         drv_go,
  output logic         crc_chk,
  output logic         crc_err,
  output logic         result_copy,
  output logic         host_irq
);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_HOPEN, S_DOPEN, S_XFER, S_DRAIN, S_DCLOSE, S_HCLOSE
  } state_t;

  state_t st;
  logic [W-1:0] h_crc, d_crc;
  logic h_take, d_take;

  function automatic logic [W-1:0] crc_next(input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] r;
    r = c;
    for (int i = W - 1; i >= 0; i--) begin
      if (r[W-1] ^ d[i]) r = {r[W-2:0], 1'b0} ^ CRC_POLY;
      else               r = {r[W-2:0], 1'b0};
    end
    return r;
  endfunction

  assign host_pause = host_req & host_ack & in_full;
  assign drv_go     = drv_req & drv_ack & ~drv_pause & ~out_empty & (st != S_DOPEN);
  assign h_take     = h_word_vld & host_req & host_ack;
  assign d_take     = d_word_vld & drv_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      host_req    <= 1'b0;
      drv_req     <= 1'b0;
      h_crc       <= CRC_SEED;
      d_crc       <= CRC_SEED;
      crc_chk     <= 1'b0;
      crc_err     <= 1'b0;
      result_copy <= 1'b0;
      host_irq    <= 1'b0;
    end else begin
      crc_chk     <= 1'b0;
      result_copy <= 1'b0;
      host_irq    <= 1'b0;
      if (h_take) h_crc <= crc_next(h_crc, h_word);
      if (d_take) d_crc <= crc_next(d_crc, d_word);
      case (st)
        S_IDLE:
          if (cmd_start) begin
            st      <= S_WAIT;
            crc_err <= 1'b0;
          end
        S_WAIT:
          if (drv_intrq) begin
            st          <= S_IDLE;
            result_copy <= 1'b1;
            host_irq    <= 1'b1;
          end else if (drv_dmarq) begin
            if (host_has_data) begin
              st       <= S_HOPEN;
              host_req <= 1'b1;
              h_crc    <= CRC_SEED;
            end else begin
              st      <= S_DOPEN;
              drv_req <= 1'b1;
              d_crc   <= CRC_SEED;
            end
          end
        S_HOPEN:
          if (host_ack) begin
            st      <= S_DOPEN;
            drv_req <= 1'b1;
            d_crc   <= CRC_SEED;
          end
        S_DOPEN:
          if (drv_ack) st <= host_req ? S_XFER : S_DRAIN;
        S_XFER:
          if (drv_stop) begin
            st      <= S_DCLOSE;
            drv_req <= 1'b0;
          end else if (host_stop) begin
            st       <= S_HCLOSE;
            host_req <= 1'b0;
          end
        S_DRAIN:
          if (drv_stop || out_empty) begin
            st      <= S_DCLOSE;
            drv_req <= 1'b0;
          end
        S_DCLOSE:
          if (!drv_ack) begin
            crc_chk <= 1'b1;
            if (d_crc != drv_crc_in) crc_err <= 1'b1;
            if (host_req) begin
              st       <= S_HCLOSE;
              host_req <= 1'b0;
            end else begin
              st <= S_WAIT;
            end
          end
        S_HCLOSE:
          if (!host_ack) begin
            crc_chk <= 1'b1;
            if (h_crc != host_crc_in) crc_err <= 1'b1;
            st <= drv_req ? S_DRAIN : S_WAIT;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/udma_flow_ctrl_chk.sv
module udma_flow_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic host_req,
  input logic drv_req,
  input logic drv_ack,
  input logic drv_go,
  input logic drv_stop,
  input logic out_empty,
  input logic host_irq,
  input logic crc_chk,
  input logic crc_err
);

  assert_host_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_req) |-> !drv_req);

  assert_go_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_go |-> (drv_req && !out_empty));

  assert_drive_closed_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_req) |-> (drv_req || !drv_ack));

  assert_drain_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drv_req) && !host_req) |-> $past(out_empty || drv_stop));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);

  assert_irq_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (!host_req && !drv_req));

  assert_err_on_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> crc_chk);

endmodule

bind udma_flow_ctrl udma_flow_ctrl_chk u_chk (.*);

// File: tb/udma_flow_ctrl_bench.sv
`timescale 1ns/1ps
module udma_flow_ctrl_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, drv_dmarq = 0, drv_pause = 0, drv_stop = 0, drv_intrq = 0;
  logic host_stop = 0, host_has_data = 0, in_full = 0, out_empty = 1;
  logic host_ack = 0, drv_ack = 0, h_word_vld = 0, d_word_vld = 0;
  logic [W-1:0] h_word = 0, d_word = 0, host_crc_in = 0, drv_crc_in = 0;
  logic host_req, drv_req, host_pause, drv_go, crc_chk, crc_err, result_copy, host_irq;

  always #4 clk = ~clk;

  udma_flow_ctrl u_udma_flow_ctrl (.*);

  int checks = 0, fails = 0, cycles = 0;
  bit bad_h = 0, bad_d = 0;

  // peers: acknowledge follows request half a cycle later
  always @(negedge clk) begin
    host_ack <= host_req;
    drv_ack  <= drv_req;
  end

  // reference model
  int ph = 0; // 0 idle 1 wait 2 hopen 3 dopen 4 xfer 5 drain 6 dclose 7 hclose
  bit eh = 0, ed = 0, echk = 0, eerr = 0, eres = 0, eirq = 0;
  logic [W-1:0] m_hcrc = 16'h4ABA, m_dcrc = 16'h4ABA;

  function automatic logic [W-1:0] crc16(input logic [W-1:0] c, input logic [W-1:0] w);
    for (int i = 15; i >= 0; i--) begin
      bit fb = c[15] ^ w[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  function automatic bit exp_go();
    return ed && drv_ack && !drv_pause && !out_empty && ph != 3;
  endfunction

  always @(negedge clk) begin
    host_crc_in <= m_hcrc ^ {15'd0, bad_h};
    drv_crc_in  <= m_dcrc ^ {15'd0, bad_d};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; eh = 0; ed = 0; echk = 0; eerr = 0; eres = 0; eirq = 0;
      m_hcrc = 16'h4ABA; m_dcrc = 16'h4ABA;
    end else begin
      int nph;
      echk = 0; eres = 0; eirq = 0;
      nph = ph;
      if (h_word_vld && eh && host_ack) m_hcrc = crc16(m_hcrc, h_word);
      if (d_word_vld && exp_go()) m_dcrc = crc16(m_dcrc, d_word);
      if (ph == 0 && cmd_start) begin nph = 1; eerr = 0; end
      else if (ph == 1 && drv_intrq) begin nph = 0; eres = 1; eirq = 1; end
      else if (ph == 1 && drv_dmarq && host_has_data) begin nph = 2; eh = 1; m_hcrc = 16'h4ABA; end
      else if (ph == 1 && drv_dmarq) begin nph = 3; ed = 1; m_dcrc = 16'h4ABA; end
      else if (ph == 2 && host_ack) begin nph = 3; ed = 1; m_dcrc = 16'h4ABA; end
      else if (ph == 3 && drv_ack) nph = eh ? 4 : 5;
      else if (ph == 4 && drv_stop) begin nph = 6; ed = 0; end
      else if (ph == 4 && host_stop) begin nph = 7; eh = 0; end
      else if (ph == 5 && (drv_stop || out_empty)) begin nph = 6; ed = 0; end
      else if (ph == 6 && !drv_ack) begin
        echk = 1;
        if (bad_d) eerr = 1;
        if (eh) begin eh = 0; nph = 7; end else nph = 1;
      end else if (ph == 7 && !host_ack) begin
        echk = 1;
        if (bad_h) eerr = 1;
        nph = ed ? 5 : 1;
      end
      ph = nph;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    cycles++;
    chk(rst_n ? "R2 host_req" : "R1 host_req", host_req, eh);
    chk(rst_n ? "R2 drv_req" : "R1 drv_req", drv_req, ed);
    chk(rst_n ? "R3 drv_go" : "R1 drv_go", drv_go, exp_go());
    chk(rst_n ? "R4 host_pause" : "R1 host_pause", host_pause, eh && host_ack && in_full);
    chk(rst_n ? "R8 result_copy" : "R1 result_copy", result_copy, eres);
    chk(rst_n ? "R8 host_irq" : "R1 host_irq", host_irq, eirq);
    chk(rst_n ? "R9 crc_chk" : "R1 crc_chk", crc_chk, echk);
    chk(rst_n ? "R9 crc_err" : "R1 crc_err", crc_err, eerr);
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic stream(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      h_word_vld = 1; h_word = 16'(seed * 16'h3A5 + i * 16'h1357);
      d_word_vld = 1; d_word = 16'(seed * 16'h0F1 ^ i * 16'h2468);
      in_full    = (i % 5 == 2);
      out_empty  = (i % 4 == 3);
      drv_pause  = (i % 6 == 4);
      step();
    end
    h_word_vld = 0; d_word_vld = 0; in_full = 0; out_empty = 0; drv_pause = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    // R11: idle ignores everything but cmd_start
    drv_dmarq = 1; host_has_data = 1; drv_stop = 1; host_stop = 1; drv_intrq = 1;
    step(4);
    chk("R11 host_req idle", host_req, 0);
    chk("R11 drv_req idle", drv_req, 0);
    chk("R11 host_irq idle", host_irq, 0);
    drv_dmarq = 0; drv_stop = 0; host_stop = 0; drv_intrq = 0;

    // first burst, drive-initiated stop, matching CRCs
    cmd_start = 1; step(); cmd_start = 0;
    drv_dmarq = 1;
    while (!host_req) step();
    chk("R2 drive not yet open", drv_req, 0);
    while (!drv_req) step();
    chk("R2 host acked before drive", host_ack, 1);
    drv_dmarq = 0;
    while (!drv_ack) step();
    step();
    stream(14, 1);
    drv_stop = 1; step(); drv_stop = 0;
    chk("R5 drive dropped", drv_req, 0);
    chk("R5 host held", host_req, 1);
    while (host_req) step();
    chk("R5 drive closed before host", drv_ack, 0);
    step(3);
    chk("R9 matching crc", crc_err, 0);

    // second burst, host-initiated stop, drain, bad drive CRC
    bad_d = 1;
    drv_dmarq = 1;
    while (!drv_ack) step();
    drv_dmarq = 0;
    step();
    stream(6, 2);
    host_stop = 1; step(); host_stop = 0;
    chk("R6 host dropped", host_req, 0);
    chk("R6 drive held", drv_req, 1);
    for (int i = 0; i < 5; i++) begin
      d_word_vld = 1; d_word = 16'(16'h0777 + i);
      step();
    end
    d_word_vld = 0;
    chk("R6 still draining", drv_req, 1);
    out_empty = 1;
    while (drv_req) step();
    step(3);
    chk("R9 bad crc flagged", crc_err, 1);
    bad_d = 0;

    // drive-only reopen
    host_has_data = 0; out_empty = 0;
    drv_dmarq = 1;
    while (!drv_req) step();
    chk("R7 host stays closed", host_req, 0);
    drv_dmarq = 0;
    while (!drv_ack) step();
    for (int i = 0; i < 4; i++) begin
      d_word_vld = 1; d_word = 16'(16'h1100 + i);
      step();
      chk("R7 host closed while draining", host_req, 0);
    end
    d_word_vld = 0; out_empty = 1;
    while (drv_req) step();
    step(3);
    chk("R9 error sticky", crc_err, 1);

    // simultaneous stops
    host_has_data = 1; out_empty = 0;
    drv_dmarq = 1;
    while (!drv_ack) step();
    drv_dmarq = 0;
    step(2);
    host_stop = 1; drv_stop = 1; step(); host_stop = 0; drv_stop = 0;
    chk("R10 drive stop wins drv_req", drv_req, 0);
    chk("R10 drive stop wins host_req", host_req, 1);
    while (host_req) step();
    step(3);

    // interrupt beats request
    drv_intrq = 1; drv_dmarq = 1; step(); drv_intrq = 0; drv_dmarq = 0;
    chk("R8 irq pulse", host_irq, 1);
    chk("R8 result copy", result_copy, 1);
    chk("R8 no channel opened", host_req, 0);
    step();
    chk("R8 irq single cycle", host_irq, 0);
    step(3);
    chk("R8 idle after interrupt", drv_req, 0);

    // new command clears the error
    cmd_start = 1; step(); cmd_start = 0;
    chk("R9 error cleared", crc_err, 0);
    drv_intrq = 1; step(); drv_intrq = 0;
    step(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule